// File: doc/BRIEF.md
# H-Bridge Drive Sequencer With Dead Time

This block turns the logic-level controls of one full bridge into the four switch commands that drive its transistors: the high-side (source) and low-side (sink) switch on leg A, and the same pair on leg B. A direction input selects which diagonal pair conducts. An active-high disable input turns the whole bridge off. A chopping input from an external current-limit latch gates only the source switch of the conducting diagonal. A fault level, which combines over-temperature and supply-undervoltage detection with their hysteresis already applied, forces every switch off.

Whenever the synchronised direction reverses, all four switches are held off for a fixed number of clock cycles before the new diagonal turns on. This stops the two switches of one leg from conducting at the same time. A further reversal inside that window starts the count again. The direction and disable inputs come from outside the clock domain, so they pass through a synchroniser chain first. The chopping and fault inputs are taken as synchronous.

Top module: `hbridge_seq`

## Requirements
- R1: While the synchronised disable is high, all four outputs are 0, whatever the direction or chopping inputs do. Clearing disable brings the selected pair back on.
- R2: With disable low and direction high, the outputs {src_a,snk_a,src_b,snk_b} are 4'b1001 when chopping is enabled. Current then flows from leg A to leg B.
- R3: With disable low and direction low, the outputs are 4'b0110 when chopping is enabled. Current then flows from leg B to leg A.
- R4: After a reversal of the synchronised direction, all outputs are 0 for exactly DEAD_CYCLES cycles. The newly selected pair turns on in the next cycle.
- R5: A direction reversal that arrives during a dead window restarts the count, so the new window runs for a full DEAD_CYCLES cycles from that reversal.
- R6: With chop_src_en_i low, the source output of the selected pair is 0 and its sink output stays 1 (4'b0001 forward, 4'b0100 reverse). This takes effect one clock after the input changes.
- R7: With fault_i high, all outputs are 0 one clock later. When fault_i clears, normal drive resumes one clock later, with no dead window.
- R8: The source and sink outputs of one leg are never both 1, and at most one source output is 1.
- R9: A change on phase_i or bridge_off_i reaches the outputs after SYNC_STAGES+1 clock edges. Before that, the previous outputs hold.
- R10: During reset and after it is released, all outputs are 0 until a drive command has passed the synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_i | input | 1 | Direction: 1 = A to B, 0 = B to A (asynchronous) |
| bridge_off_i | input | 1 | 1 turns the whole bridge off (asynchronous) |
| chop_src_en_i | input | 1 | Current-limit latch output: 0 turns off the active source |
| fault_i | input | 1 | Thermal or undervoltage shutdown level |
| src_a_o | output | 1 | Leg A high-side switch command |
| snk_a_o | output | 1 | Leg A low-side switch command |
| src_b_o | output | 1 | Leg B high-side switch command |
| snk_b_o | output | 1 | Leg B low-side switch command |

## Verification
The bench builds the block with SYNC_STAGES=2 and DEAD_CYCLES=4. With a dead window that short, the bench can issue a second reversal two cycles into the window and still observe the cycle where drive would have resumed without the restart. The two-stage chain lets the bench check separately that the old pair holds through the synchroniser delay and that the outputs switch exactly one edge later. Both timings are checked against the faster one-clock path of the chopping and fault inputs.

// File: rtl/hb_pkg.sv
package hb_pkg;

    // Switch commands for one bridge, packed as {src_a, snk_a, src_b, snk_b}
    typedef struct packed {
        logic src_a;
        logic snk_a;
        logic src_b;
        logic snk_b;
    } bridge_cmd_t;

    localparam bridge_cmd_t CMD_OFF = '0;

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    // Stage 0 takes the raw input; each later stage takes the one before it
    assign stage_d[0] = d_i;
    for (genvar g = 1; g < STAGES; g++) begin : g_chain
        assign stage_d[g] = stage_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/hb_deadtime.sv
module hb_deadtime #(
    parameter int DEAD_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_i,
    output logic dead_o
);

    localparam int CW = (DEAD_CYCLES > 1) ? $clog2(DEAD_CYCLES) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(DEAD_CYCLES - 1);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
    } dt_state_t;

    dt_state_t st_d, st_q;
    logic      toggle;

    // The reversal cycle itself is the first dead cycle; the counter covers the rest
    always_comb begin
        st_d      = st_q;
        toggle    = (phase_i != st_q.prev);
        st_d.prev = phase_i;
        if (toggle) begin
            st_d.cnt = RELOAD;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dead_o = toggle || (st_q.cnt != '0);

    // Any reversal, including one inside a running window, reloads the full count
    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase_i) |=> (st_q.cnt == RELOAD));

    // Without a reversal the window only shrinks
    p_countdown_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0 && phase_i == st_q.prev) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

endmodule

// File: rtl/hbridge_seq.sv
module hbridge_seq #(
    parameter int SYNC_STAGES = 2,
    parameter int DEAD_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_i,
    input  logic bridge_off_i,
    input  logic chop_src_en_i,
    input  logic fault_i,
    output logic src_a_o,
    output logic snk_a_o,
    output logic src_b_o,
    output logic snk_b_o
);
    import hb_pkg::*;

    logic [1:0]  sync_q;
    logic        phase_s;
    logic        off_s;
    logic        dead;
    bridge_cmd_t cmd_d, cmd_q;

    // Direction resets to 0 and disable resets to 1, so the bridge wakes up off
    hb_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b01)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({phase_i, bridge_off_i}),
        .q_o  (sync_q)
    );

    assign phase_s = sync_q[1];
    assign off_s   = sync_q[0];

    hb_deadtime #(
        .DEAD_CYCLES(DEAD_CYCLES)
    ) u_dead (
        .clk    (clk),
        .rst_n  (rst_n),
        .phase_i(phase_s),
        .dead_o (dead)
    );

    // Drive the selected diagonal; chopping gates only its source switch
    always_comb begin
        cmd_d = CMD_OFF;
        if (!fault_i && !off_s && !dead) begin
            if (phase_s) begin
                cmd_d.src_a = chop_src_en_i;
                cmd_d.snk_b = 1'b1;
            end else begin
                cmd_d.src_b = chop_src_en_i;
                cmd_d.snk_a = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= CMD_OFF;
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign src_a_o = cmd_q.src_a;
    assign snk_a_o = cmd_q.snk_a;
    assign src_b_o = cmd_q.src_b;
    assign snk_b_o = cmd_q.snk_b;

    p_leg_a_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_a_o && snk_a_o));

    p_leg_b_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_b_o && snk_b_o));

    p_one_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({src_a_o, src_b_o}));

    p_fault_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> (cmd_q == CMD_OFF));

    p_disable_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        off_s |=> (cmd_q == CMD_OFF));

    p_reverse_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase_s) |=> (cmd_q == CMD_OFF));

endmodule

// File: tb/tb_hbridge_seq.sv
module tb_hbridge_seq;
    localparam int S = 2;
    localparam int D = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ph = 1'b0;
    logic off = 1'b1;
    logic se = 1'b1;
    logic ft = 1'b0;
    logic sa, ka, sb, kb;

    int cyc = 0;
    int errors = 0;
    int checks = 0;
    int leg_viol = 0;
    int c = 0;

    typedef struct {
        int         at;
        logic [3:0] val;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hbridge_seq #(.SYNC_STAGES(S), .DEAD_CYCLES(D)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase_i      (ph),
        .bridge_off_i (off),
        .chop_src_en_i(se),
        .fault_i      (ft),
        .src_a_o      (sa),
        .snk_a_o      (ka),
        .src_b_o      (sb),
        .snk_b_o      (kb)
    );

    // Driver side: schedule an expected output word {src_a,snk_a,src_b,snk_b}
    function automatic void expect_out(int at, logic [3:0] v, string tag);
        exp_t e;
        e.at  = at;
        e.val = v;
        e.tag = tag;
        sb_q.push_back(e);
    endfunction

    // Monitor side: compare due items away from the rising edge
    always @(negedge clk) begin
        logic [3:0] got;
        got = {sa, ka, sb, kb};
        if (rst_n && ((sa && ka) || (sb && kb) || (sa && sb))) leg_viol++;
        for (int i = sb_q.size() - 1; i >= 0; i--) begin
            if (sb_q[i].at == cyc) begin
                checks++;
                if (got !== sb_q[i].val) begin
                    errors++;
                    $display("FAIL %s: cycle %0d got %b expected %b", sb_q[i].tag, cyc, got, sb_q[i].val);
                end
                sb_q.delete(i);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        c = cyc;
        expect_out(c + 1, 4'b0000, "R10 reset state");
        expect_out(c + 2, 4'b0000, "R10 idle after reset");
        tick(3);

        // Reverse drive through the synchroniser
        c = cyc; off = 1'b0;
        expect_out(c + S, 4'b0000, "R9 disable change not yet visible");
        expect_out(c + S + 1, 4'b0110, "R3 reverse pair");
        tick(8);

        // Reversal to forward with dead window
        c = cyc; ph = 1'b1;
        expect_out(c + S, 4'b0110, "R9 old pair holds");
        expect_out(c + S + 1, 4'b0000, "R4 dead window start");
        expect_out(c + S + D, 4'b0000, "R4 dead window end");
        expect_out(c + S + D + 1, 4'b1001, "R2 forward pair");
        tick(D + 8);

        // Chopping in forward direction
        c = cyc; se = 1'b0;
        expect_out(c + 1, 4'b0001, "R6 forward sink holds");
        tick(3);
        c = cyc; se = 1'b1;
        expect_out(c + 1, 4'b1001, "R6 forward source back");
        tick(3);

        // Restart of the dead window by a second reversal
        c = cyc; ph = 1'b0;
        tick(2);
        ph = 1'b1;
        expect_out(c + S + 1, 4'b0000, "R4 first reversal off");
        expect_out(c + S + D + 1, 4'b0000, "R5 no resume at original end");
        expect_out(c + 2 + S + D, 4'b0000, "R5 restarted window end");
        expect_out(c + 2 + S + D + 1, 4'b1001, "R5 resume after restart");
        tick(D + 10);

        // Fault in forward direction
        c = cyc; ft = 1'b1;
        expect_out(c + 1, 4'b0000, "R7 fault forces off");
        expect_out(c + 3, 4'b0000, "R7 fault holds off");
        tick(4);
        c = cyc; ft = 1'b0;
        expect_out(c + 1, 4'b1001, "R7 resume after fault");
        tick(3);

        // Reverse again, then chop and fault there
        c = cyc; ph = 1'b0;
        expect_out(c + S + D + 1, 4'b0110, "R3 reverse after reversal");
        tick(D + 6);
        c = cyc; se = 1'b0;
        expect_out(c + 1, 4'b0100, "R6 reverse sink holds");
        tick(2);
        se = 1'b1;
        tick(2);
        c = cyc; ft = 1'b1;
        expect_out(c + 1, 4'b0000, "R7 fault in reverse");
        tick(2);
        c = cyc; ft = 1'b0;
        expect_out(c + 1, 4'b0110, "R7 reverse resumes");
        tick(3);

        // Disable, with other inputs moving while off
        c = cyc; off = 1'b1;
        expect_out(c + S, 4'b0110, "R9 disable not yet visible");
        expect_out(c + S + 1, 4'b0000, "R1 disabled");
        tick(4);
        c = cyc; se = 1'b0;
        expect_out(c + 1, 4'b0000, "R1 chop ignored while off");
        tick(2);
        c = cyc; se = 1'b1; ph = 1'b1;
        expect_out(c + S + 1, 4'b0000, "R1 phase ignored while off");
        tick(D + 8);
        c = cyc; off = 1'b0;
        expect_out(c + S + 1, 4'b1001, "R1 re-enable forward");
        tick(6);

        checks++;
        if (leg_viol != 0) begin
            errors++;
            $display("FAIL R8 leg overlap: got %0d cycles expected 0", leg_viol);
        end
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R9 pending expectations: got %0d expected 0", sb_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R10: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule